// File: doc/BRIEF.md
# Masked Packed Unsigned-to-Double Converter

This block turns a vector of unsigned 32-bit integers into a vector of IEEE-754 double-precision values. Each 32-bit input lane feeds one 64-bit output lane, so the source vector is half as wide as the result. A 2-bit length code selects 2, 4 or 8 active lanes, which gives results 128, 256 or 512 bits wide. Every result bit above the active length is cleared.

Each lane can use an optional per-lane write mask. When a mask bit is clear, that lane either keeps the caller's prior destination value (merge) or becomes zero (zeroing). A broadcast option makes every active lane convert the lowest source element. A 4-bit reserved field must hold all ones. If it does not, or if the length code is not one of the three legal codes, the operation is flagged illegal and the prior destination is returned untouched. A 32-bit integer always fits in the 53-bit significand, so every conversion is exact. No rounding control exists and no exception is raised.

Operations enter over a valid/ready stream and leave through a one-deep registered output stage that also uses valid/ready. An input is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the result is held without change.

Top module: `u2d_vec_convert`

## Requirements
- R1: A zero lane input gives all-zero 64 bits. A nonzero input v gives sign 0, exponent 1023+p where p is the index of the highest set bit of v, and a fraction made of the bits of v below p, left-aligned in the 52-bit field. The result equals the exact value of v.
- R2: For lane j, the output occupies `out_data[64j+63:64j]` and, when broadcast is off, converts `in_src[32j+31:32j]`.
- R3: When `in_mask_en` is 0, every active lane is converted and `in_mask` has no effect.
- R4: When `in_mask_en` is 1, `in_zero_mode` is 0 and `in_mask[j]` is 0, active lane j equals `in_old[64j+63:64j]`.
- R5: When `in_mask_en` is 1, `in_zero_mode` is 1 and `in_mask[j]` is 0, active lane j is zero.
- R6: When `in_bcast` is 1, every active lane that converts uses `in_src[31:0]`.
- R7: `in_vlen` codes 0, 1 and 2 select 2, 4 and 8 lanes. All output bits from lane count × 64 up to bit 511 are zero.
- R8: If `in_rsv` is not 4'b1111, `out_illegal` is 1 and `out_data` equals `in_old` in full.
- R9: `in_vlen` code 3 is illegal and behaves the same way as in R8.
- R10: An accepted input shows its result with `out_valid` high after exactly one clock edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_illegal` stay unchanged.
- R11: During and right after reset (`rst_n` low, active low), `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_vlen | input | 2 | Length code: 0=2 lanes, 1=4, 2=8, 3=illegal |
| in_mask_en | input | 1 | Per-lane mask in use |
| in_mask | input | 8 | Per-lane write mask |
| in_zero_mode | input | 1 | Unselected lanes: 1=zero, 0=keep prior value |
| in_bcast | input | 1 | All lanes convert the lowest source element |
| in_rsv | input | 4 | Reserved field, must be 4'b1111 |
| in_src | input | 256 | Packed unsigned 32-bit source lanes |
| in_old | input | 512 | Prior destination contents |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 512 | Packed double results |
| out_illegal | output | 1 | Operation was illegal; out_data is the prior destination |

## Verification
An operation's result is due one clock edge after the edge that accepts it. It is then held for as long as `out_ready` stays low. The driver samples `in_ready` half a cycle before each rising edge, so it knows exactly which edge accepts an item. At the falling edge that follows, it confirms that `out_valid` is high. A monitor reads the output at every falling edge where `out_valid` and `out_ready` are both high, since that is the rising edge where the result leaves. It compares that result with the oldest expected item queued by the driver. While the output is stalled, the monitor also checks that it does not change from one falling edge to the next.

// File: rtl/u2d_pkg.sv
package u2d_pkg;
  parameter int LANE_IN_W  = 32;
  parameter int LANE_OUT_W = 64;
  parameter int EXP_W      = 11;
  parameter int FRAC_W     = 52;
  parameter int EXP_BIAS   = 1023;
  parameter int RSV_W      = 4;
  parameter logic [RSV_W-1:0] RSV_OK = '1;

  typedef enum logic [1:0] {
    VL_2  = 2'd0,
    VL_4  = 2'd1,
    VL_8  = 2'd2,
    VL_NA = 2'd3
  } vlen_e;

  function automatic logic [4:0] lanes_of(input logic [1:0] code);
    return 5'd2 << code;
  endfunction
endpackage

// File: rtl/u2d_lane.sv
module u2d_lane
  import u2d_pkg::*;
(
  input  logic [LANE_IN_W-1:0]  val,
  output logic [LANE_OUT_W-1:0] dbl
);
  localparam int IDX_W = $clog2(LANE_IN_W);
  localparam int PAD_W = FRAC_W - LANE_IN_W;
  localparam int SH_W  = IDX_W + 1;

  logic [IDX_W-1:0]     msb;
  logic [SH_W-1:0]      shamt;
  logic [LANE_IN_W-1:0] aligned;
  logic [EXP_W-1:0]     expo;

  always_comb begin
    msb = '0;
    for (int i = 0; i < LANE_IN_W; i++) begin
      if (val[i]) msb = IDX_W'(i);
    end
    shamt   = SH_W'(LANE_IN_W - int'(msb));
    aligned = val << shamt;
    expo    = EXP_W'(EXP_BIAS + int'(msb));
    if (val == '0) dbl = '0;
    else           dbl = {1'b0, expo, aligned, {PAD_W{1'b0}}};
  end

  always_comb begin
    if (!$isunknown(val)) begin
      AST_ZERO_IN: assert (val != '0 || dbl == '0) else $error("zero input not +0.0"); // R1
      AST_SIGN_CLEAR: assert (dbl[LANE_OUT_W-1] == 1'b0) else $error("sign bit set"); // R1
    end
  end
endmodule

// File: rtl/u2d_lane_sel.sv
module u2d_lane_sel
  import u2d_pkg::*;
(
  input  logic [LANE_OUT_W-1:0] conv,
  input  logic [LANE_OUT_W-1:0] old,
  input  logic                  in_range,
  input  logic                  take,
  input  logic                  zero_mode,
  output logic [LANE_OUT_W-1:0] res
);
  always_comb begin
    if (!in_range)      res = '0;
    else if (take)      res = conv;
    else if (zero_mode) res = '0;
    else                res = old;
  end
endmodule

// File: rtl/u2d_vec_convert.sv
module u2d_vec_convert
  import u2d_pkg::*;
#(
  parameter int MAX_LANES = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic [1:0]                      in_vlen,
  input  logic                            in_mask_en,
  input  logic [MAX_LANES-1:0]            in_mask,
  input  logic                            in_zero_mode,
  input  logic                            in_bcast,
  input  logic [RSV_W-1:0]                in_rsv,
  input  logic [MAX_LANES*LANE_IN_W-1:0]  in_src,
  input  logic [MAX_LANES*LANE_OUT_W-1:0] in_old,
  output logic                            out_valid,
  input  logic                            out_ready,
  output logic [MAX_LANES*LANE_OUT_W-1:0] out_data,
  output logic                            out_illegal
);
  localparam int DST_W = MAX_LANES * LANE_OUT_W;

  logic [4:0]           n_lanes;
  logic [MAX_LANES-1:0] lane_on;
  logic [DST_W-1:0]     merged;
  logic [DST_W-1:0]     next_data;
  logic                 bad_op;
  logic                 accept;
  logic                 valid_q;
  logic                 illegal_q;
  logic [DST_W-1:0]     data_q;
  logic [4:0]           lanes_q;

  assign n_lanes = lanes_of(in_vlen);
  assign bad_op  = (in_rsv != RSV_OK) || (vlen_e'(in_vlen) == VL_NA);

  always_comb begin
    for (int j = 0; j < MAX_LANES; j++) lane_on[j] = (j < int'(n_lanes));
  end

  for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
    logic [LANE_IN_W-1:0]  pick;
    logic [LANE_OUT_W-1:0] conv;
    assign pick = in_bcast ? in_src[LANE_IN_W-1:0] : in_src[j*LANE_IN_W +: LANE_IN_W];
    u2d_lane u_cvt (.val(pick), .dbl(conv));
    u2d_lane_sel u_sel (
      .conv      (conv),
      .old       (in_old[j*LANE_OUT_W +: LANE_OUT_W]),
      .in_range  (lane_on[j]),
      .take      (!in_mask_en || in_mask[j]),
      .zero_mode (in_zero_mode),
      .res       (merged[j*LANE_OUT_W +: LANE_OUT_W])
    );
  end

  assign next_data = bad_op ? in_old : merged;
  assign in_ready  = !valid_q || out_ready;
  assign accept    = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      data_q    <= '0;
      lanes_q   <= 5'd2;
    end else begin
      if (in_ready) valid_q <= in_valid;
      if (accept) begin
        data_q    <= next_data;
        illegal_q <= bad_op;
        lanes_q   <= n_lanes;
      end
    end
  end

  assign out_valid   = valid_q;
  assign out_data    = data_q;
  assign out_illegal = illegal_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_illegal)); // R10
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R10
  AST_BAD_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_rsv != RSV_OK |=> out_valid && out_illegal); // R8
  AST_BAD_VLEN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_vlen == 2'd3 |=> out_valid && out_illegal); // R9
  AST_TAIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_illegal |-> (out_data >> (int'(lanes_q) * LANE_OUT_W)) == '0); // R7
endmodule

// File: tb/u2d_vec_convert_tb.sv
`timescale 1ns/1ps
module u2d_vec_convert_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   in_vlen = '0;
  logic         in_mask_en = 1'b0;
  logic [7:0]   in_mask = '0;
  logic         in_zero_mode = 1'b0;
  logic         in_bcast = 1'b0;
  logic [3:0]   in_rsv = 4'hF;
  logic [255:0] in_src = '0;
  logic [511:0] in_old = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [511:0] out_data;
  logic         out_illegal;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [512:0] exp_q[$];
  string        tag_q[$];

  always #2 clk = ~clk;

  u2d_vec_convert u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_vlen(in_vlen), .in_mask_en(in_mask_en), .in_mask(in_mask),
    .in_zero_mode(in_zero_mode), .in_bcast(in_bcast), .in_rsv(in_rsv),
    .in_src(in_src), .in_old(in_old), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_illegal(out_illegal)
  );

  function automatic logic [63:0] ref_cvt(input logic [31:0] v);
    real r;
    r = real'(longint'({32'b0, v}));
    return $realtobits(r);
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] x;
    for (int i = 0; i < 8; i++) x[i*32 +: 32] = $urandom;
    return x;
  endfunction

  function automatic logic [511:0] rnd512();
    return {rnd256(), rnd256()};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [512:0] act, input logic [512:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: entered and left at a falling edge
  task automatic send(input logic [1:0] vl, input logic men, input logic [7:0] m,
                      input logic zm, input logic bc, input logic [3:0] rsv,
                      input logic [255:0] src, input logic [511:0] old, input string tag);
    logic [511:0] e;
    logic         bad;
    int           nl;
    bit           acc;
    bad = (rsv != 4'hF) || (vl == 2'd3);
    nl  = 2 << vl;
    e   = '0;
    if (bad) e = old;
    else begin
      for (int j = 0; j < 8; j++) begin
        if (j < nl) begin
          if (!men || m[j]) e[j*64 +: 64] = ref_cvt(bc ? src[31:0] : src[j*32 +: 32]);
          else if (!zm)     e[j*64 +: 64] = old[j*64 +: 64];
        end
      end
    end
    exp_q.push_back({bad, e});
    tag_q.push_back(tag);
    in_vlen = vl; in_mask_en = men; in_mask = m; in_zero_mode = zm;
    in_bcast = bc; in_rsv = rsv; in_src = src; in_old = old;
    in_valid = 1'b1;
    acc = 1'b0;
    do begin
      #1 acc = in_ready;
      @(posedge clk);
      if (!acc) @(negedge clk);
    end while (!acc);
    #0.2 in_valid = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b1, "R10 latency", {512'b0, out_valid}, 513'd1);
  endtask

  // consumer back-pressure pattern
  always @(posedge clk) begin
    #0.5;
    cyc++;
    out_ready = !((cyc % 5 == 3) || (cyc > 300 && cyc < 306));
  end

  // monitor
  logic         stall_prev = 1'b0;
  logic [512:0] held;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev)
        check(out_valid && {out_illegal, out_data} === held, "R10 hold",
              {out_illegal, out_data}, held);
      stall_prev = out_valid && !out_ready;
      held       = {out_illegal, out_data};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R10 extra output", {out_illegal, out_data}, '0);
        else begin
          logic [512:0] ex;
          string        t;
          ex = exp_q.pop_front();
          t  = tag_q.pop_front();
          check({out_illegal, out_data} === ex, t, {out_illegal, out_data}, ex);
        end
      end
    end
  end

  bit done = 1'b0;
  initial begin
    #600000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R11 in reset",
          {511'b0, out_valid, in_ready}, 513'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && in_ready === 1'b1, "R11 after reset",
          {511'b0, out_valid, in_ready}, 513'd1);

    // R1/R2/R3 corner values, no mask
    send(2'd2, 1'b0, 8'h00, 1'b0, 1'b0, 4'hF,
         {32'd7, 32'h8000_0000, 32'd2, 32'd3, 32'h0001_0000, 32'hFFFF_FFFF, 32'd1, 32'd0},
         rnd512(), "R1 corner values");
    send(2'd2, 1'b0, 8'h5A, 1'b1, 1'b0, 4'hF, rnd256(), rnd512(), "R3 mask ignored");
    for (int k = 0; k < 6; k++)
      send(2'd2, 1'b0, 8'h00, 1'b0, 1'b0, 4'hF, rnd256(), rnd512(), "R2 lane mapping");
    // all mask patterns, merge then zeroing
    for (int m = 0; m < 256; m++)
      send(2'd2, 1'b1, 8'(m), 1'b0, 1'b0, 4'hF, rnd256(), rnd512(), "R4 merge mask");
    for (int m = 0; m < 256; m++)
      send(2'd2, 1'b1, 8'(m), 1'b1, 1'b0, 4'hF, rnd256(), rnd512(), "R5 zero mask");
    // lengths and broadcast
    for (int v = 0; v < 3; v++) begin
      for (int b = 0; b < 2; b++) begin
        send(2'(v), 1'b0, 8'h00, 1'b0, 1'(b), 4'hF, rnd256(), rnd512(), "R7 length tail");
        send(2'(v), 1'b1, 8'hA5, 1'(b), 1'(b), 4'hF, rnd256(), rnd512(), "R6 broadcast masked");
      end
    end
    send(2'd2, 1'b0, 8'h00, 1'b0, 1'b1, 4'hF, {224'h0, 32'hFFFF_FFFF}, rnd512(), "R6 broadcast max");
    send(2'd0, 1'b0, 8'h00, 1'b0, 1'b1, 4'hF, {rnd256() & ~256'hFFFF_FFFF}, rnd512(), "R6 broadcast zero");
    // illegal encodings
    for (int r = 0; r < 15; r++)
      send(2'd1, 1'b0, 8'h00, 1'b0, 1'b0, 4'(r), rnd256(), rnd512(), "R8 reserved field");
    send(2'd3, 1'b0, 8'h00, 1'b0, 1'b0, 4'hF, rnd256(), rnd512(), "R9 bad length");
    send(2'd3, 1'b1, 8'h0F, 1'b1, 1'b1, 4'hF, rnd256(), rnd512(), "R9 bad length masked");
    send(2'd2, 1'b0, 8'h00, 1'b0, 1'b0, 4'hF, rnd256(), rnd512(), "R10 after illegal");

    for (int w = 0; w < 50 && exp_q.size() != 0; w++) @(negedge clk);
    check(exp_q.size() == 0, "R10 drain", 513'(exp_q.size()), '0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule